// File: doc/BRIEF.md
# Camera Receiver Shadowed Control Registers

This block is the memory-mapped control store of a serial camera receiver. Software reaches it over a plain 32-bit bus that has a byte address, a write strobe, write data and combinational read data. There are four words: global control, PHY control, stream configuration and frame resolution. A few global fields (enable, pair polarity swap, wrapper clock select) and the PHY lane-enable field act at once. The stream parameters are different. These are data type, lane count, width, height, high-speed settle count and output alignment. Software writes them into staged copies, and the datapath only sees them after an explicit shadow-update command. This lets software rewrite a whole stream setup without the receiver ever seeing half of it.

Two bits of the global word are commands, not stored state. One requests the shadow update. The other requests a soft reset, which clears the active parameter set and produces a one-cycle reset pulse for the receive logic. The block also turns the lane field into a lane count and gates the lane enables with the global enable.

Top module: `cam_rx_ctrl_regs`

## Requirements
- R1: After `rst_n` is released, every mapped word reads zero. `soft_rst_pulse`, `lane_en`, `rx_enable`, `pair_swap`, `ext_clk_sel` and all active fields are zero, and `act_lanes` is 1.
- R2: The global word is at offset 0x00. Bit 0 is enable and drives `rx_enable`. Bit 8 is wrapper clock select and drives `ext_clk_sel`. Bit 20 is staged 32-bit alignment (0 means 24-bit). Bit 31 is pair swap and drives `pair_swap`. All four read back as written. Bits 4 and 16 always read zero, and every other bit also reads zero.
- R3: The PHY word is at offset 0x04. Bits 4:0 are the lane enables and bits 31:27 are the staged settle count. Only these bits read back; all others read zero.
- R4: The configuration word is at offset 0x08. Bits 7:2 are the staged data-type code (for example 0x1E YCbCr 4:2:2 8-bit, 0x2A to 0x2C RAW8 to RAW12, 0x30 to 0x33 user types) and bits 1:0 are lanes minus one. Bits 31:8 read zero.
- R5: The resolution word is at offset 0x2C. Width is in bits 31:16 and height in bits 15:0, and both read back across the full range up to 0xFFFF.
- R6: Writes to staged fields do not change `act_*` outputs until a shadow update completes.
- R7: A write to offset 0x00 with bit 16 set loads all staged alignment, settle, type, lane, width and height values into the `act_*` outputs. The values used are those present one cycle after the write, and the outputs show them after the second rising edge.
- R8: `act_lanes` equals the active lanes-minus-one field plus one, which ranges from 1 to 4.
- R9: A write to offset 0x00 with bit 4 set drives `soft_rst_pulse` high for the cycle after the write, for one cycle per write. At the next edge all `act_*` fields go back to their reset values. Staged words keep their contents.
- R10: When the soft reset and the shadow update are requested in the same write, the reset wins and the active set ends up cleared.
- R11: A read of any unmapped or misaligned offset returns zero. A write there changes no register and no output.
- R12: `lane_en` equals PHY bits 4:0 while the enable bit is set, and is zero while it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rx_enable | output | 1 | Global receiver enable |
| pair_swap | output | 1 | Differential pair polarity swap |
| ext_clk_sel | output | 1 | External wrapper clock select |
| lane_en | output | 5 | Gated clock-lane and data-lane enables |
| soft_rst_pulse | output | 1 | One-cycle soft reset to receive logic |
| act_align32 | output | 1 | Active 32-bit output alignment |
| act_settle | output | 5 | Active high-speed settle count |
| act_dtype | output | 6 | Active data-type code |
| act_lanes | output | 3 | Active lane count, 1 to 4 |
| act_width | output | 16 | Active frame width |
| act_height | output | 16 | Active frame height |

## Verification
The soft reset and the shadow update can land in the same cycle. This happens when one control write sets both bits, and the bench checks that the active set ends at reset values rather than the staged ones. A second collision is a configuration write in the cycle right after an update request. The bench checks that the active copy takes the value that was staged at the load edge, and that the new value stays staged until the next update. A reference model, updated every edge, judges all outputs and read data.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int DATA_W   = 32;
    localparam int SETTLE_W = 5;
    localparam int LANE_W   = 5;
    localparam int DT_W     = 6;
    localparam int LM_W     = 2;
    localparam int DIM_W    = 16;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_PHY  = 'h04;
    localparam int OFF_CFG  = 'h08;
    localparam int OFF_RES  = 'h2C;

    localparam int B_EN     = 0;
    localparam int B_RST    = 4;
    localparam int B_WCLK   = 8;
    localparam int B_UPD    = 16;
    localparam int B_ALIGN  = 20;
    localparam int B_SWAP   = 31;
    localparam int SETTLE_LSB = DATA_W - SETTLE_W;
    localparam int DT_LSB   = LM_W;
    localparam int W_LSB    = DATA_W - DIM_W;

    typedef struct packed {
        logic                align32;
        logic [SETTLE_W-1:0] settle;
        logic [DT_W-1:0]     dtype;
        logic [LM_W-1:0]     lanes_m1;
        logic [DIM_W-1:0]    width;
        logic [DIM_W-1:0]    height;
    } cr_set_t;

    typedef struct packed {
        logic              en;
        logic              swap;
        logic              extclk;
        logic [LANE_W-1:0] lanes;
        cr_set_t           stg;
        logic              rst_p;
        logic              upd_p;
    } cr_bank_t;

endpackage

// File: rtl/cr_regbank.sv
module cr_regbank
    import cr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output cr_set_t             stg,
    output logic                glb_en,
    output logic                glb_swap,
    output logic                glb_extclk,
    output logic [LANE_W-1:0]   phy_lanes,
    output logic                rst_pulse,
    output logic                upd_pulse
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PHY  = ADDR_W'(OFF_PHY);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFF_RES);

    cr_bank_t bank_d, bank_q;
    logic     wr_ctrl, wr_phy, wr_cfg, wr_res;
    logic     wdata_unused;

    assign wdata_unused = ^bus_wdata;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_phy  = bus_wr && (bus_addr == A_PHY);
        wr_cfg  = bus_wr && (bus_addr == A_CFG);
        wr_res  = bus_wr && (bus_addr == A_RES);

        bank_d       = bank_q;
        bank_d.rst_p = 1'b0;
        bank_d.upd_p = 1'b0;

        if (wr_ctrl) begin
            bank_d.en          = bus_wdata[B_EN];
            bank_d.extclk      = bus_wdata[B_WCLK];
            bank_d.stg.align32 = bus_wdata[B_ALIGN];
            bank_d.swap        = bus_wdata[B_SWAP];
            bank_d.rst_p       = bus_wdata[B_RST];
            bank_d.upd_p       = bus_wdata[B_UPD];
        end
        if (wr_phy) begin
            bank_d.lanes      = bus_wdata[LANE_W-1:0];
            bank_d.stg.settle = bus_wdata[SETTLE_LSB +: SETTLE_W];
        end
        if (wr_cfg) begin
            bank_d.stg.lanes_m1 = bus_wdata[LM_W-1:0];
            bank_d.stg.dtype    = bus_wdata[DT_LSB +: DT_W];
        end
        if (wr_res) begin
            bank_d.stg.width  = bus_wdata[W_LSB +: DIM_W];
            bank_d.stg.height = bus_wdata[DIM_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]    = bank_q.en;
                bus_rdata[B_WCLK]  = bank_q.extclk;
                bus_rdata[B_ALIGN] = bank_q.stg.align32;
                bus_rdata[B_SWAP]  = bank_q.swap;
            end
            A_PHY: begin
                bus_rdata[LANE_W-1:0]              = bank_q.lanes;
                bus_rdata[SETTLE_LSB +: SETTLE_W]  = bank_q.stg.settle;
            end
            A_CFG: begin
                bus_rdata[LM_W-1:0]      = bank_q.stg.lanes_m1;
                bus_rdata[DT_LSB +: DT_W] = bank_q.stg.dtype;
            end
            A_RES: begin
                bus_rdata[W_LSB +: DIM_W] = bank_q.stg.width;
                bus_rdata[DIM_W-1:0]      = bank_q.stg.height;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stg        = bank_q.stg;
    assign glb_en     = bank_q.en;
    assign glb_swap   = bank_q.swap;
    assign glb_extclk = bank_q.extclk;
    assign phy_lanes  = bank_q.lanes;
    assign rst_pulse  = bank_q.rst_p;
    assign upd_pulse  = bank_q.upd_p;

    // R9
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[B_RST]));

    // R7
    upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[B_UPD]));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_CTRL && bus_addr != A_PHY && bus_addr != A_CFG &&
         bus_addr != A_RES) |-> bus_rdata == '0);

endmodule

// File: rtl/cr_shadow.sv
module cr_shadow
    import cr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd,
    input  logic    clr,
    input  cr_set_t stg,
    output cr_set_t act
);

    cr_set_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (clr)      act_d = '0;
        else if (upd) act_d = stg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act = act_q;

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(act_q));

    // R7
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> act_q == $past(stg));

    // R10
    act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> act_q == '0);

endmodule

// File: rtl/cr_lane_out.sv
module cr_lane_out
    import cr_pkg::*;
#(
    parameter int CNT_W = LM_W + 1
) (
    input  logic              en,
    input  logic [LANE_W-1:0] phy_lanes,
    input  logic [LM_W-1:0]   lanes_m1,
    output logic [LANE_W-1:0] lane_en,
    output logic [CNT_W-1:0]  lane_cnt
);

    always_comb begin
        lane_en  = en ? phy_lanes : '0;
        lane_cnt = CNT_W'(lanes_m1) + CNT_W'(1);
    end

    // R8
    always_comb begin
        lane_cnt_chk: assert (lane_cnt != '0 && lane_cnt <= CNT_W'(1 << LM_W));
    end

endmodule

// File: rtl/cam_rx_ctrl_regs.sv
module cam_rx_ctrl_regs
    import cr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                rx_enable,
    output logic                pair_swap,
    output logic                ext_clk_sel,
    output logic [4:0]          lane_en,
    output logic                soft_rst_pulse,
    output logic                act_align32,
    output logic [4:0]          act_settle,
    output logic [5:0]          act_dtype,
    output logic [2:0]          act_lanes,
    output logic [15:0]         act_width,
    output logic [15:0]         act_height
);

    cr_set_t           stg_set, act_set;
    logic              glb_en, upd_p, rst_p;
    logic [LANE_W-1:0] phy_lanes;

    cr_regbank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .stg        (stg_set),
        .glb_en     (glb_en),
        .glb_swap   (pair_swap),
        .glb_extclk (ext_clk_sel),
        .phy_lanes  (phy_lanes),
        .rst_pulse  (rst_p),
        .upd_pulse  (upd_p)
    );

    cr_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd_p),
        .clr   (rst_p),
        .stg   (stg_set),
        .act   (act_set)
    );

    cr_lane_out #(.CNT_W(3)) u_lanes (
        .en        (glb_en),
        .phy_lanes (phy_lanes),
        .lanes_m1  (act_set.lanes_m1),
        .lane_en   (lane_en),
        .lane_cnt  (act_lanes)
    );

    assign rx_enable      = glb_en;
    assign soft_rst_pulse = rst_p;
    assign act_align32    = act_set.align32;
    assign act_settle     = act_set.settle;
    assign act_dtype      = act_set.dtype;
    assign act_width      = act_set.width;
    assign act_height     = act_set.height;

    // R12
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> lane_en == '0);

endmodule

// File: tb/tb_cam_rx_ctrl_regs.sv
module tb_cam_rx_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_enable, pair_swap, ext_clk_sel, soft_rst_pulse, act_align32;
    logic [4:0]  lane_en, act_settle;
    logic [5:0]  act_dtype;
    logic [2:0]  act_lanes;
    logic [15:0] act_width, act_height;

    int vectors = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cam_rx_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_enable(rx_enable),
        .pair_swap(pair_swap), .ext_clk_sel(ext_clk_sel), .lane_en(lane_en),
        .soft_rst_pulse(soft_rst_pulse), .act_align32(act_align32),
        .act_settle(act_settle), .act_dtype(act_dtype), .act_lanes(act_lanes),
        .act_width(act_width), .act_height(act_height)
    );

    // reference model state: staged, active, pulses
    bit      s_en, s_swap, s_ext, s_al, a_al, p_rst, p_upd;
    int      s_set, s_ln, s_dt, s_lm, s_w, s_h;
    int      a_set, a_dt, a_lm, a_w, a_h;

    function automatic int m_read(input int a);
        case (a)
            'h00: return (int'(s_swap) << 31) | (int'(s_al) << 20) |
                         (int'(s_ext) << 8) | int'(s_en);
            'h04: return (s_set << 27) | s_ln;
            'h08: return (s_dt << 2) | s_lm;
            'h2C: return (s_w << 16) | s_h;
            default: return 0;
        endcase
    endfunction

    task automatic m_edge(input bit we, input int a, input int d);
        if (p_rst) begin
            a_al = 0; a_set = 0; a_dt = 0; a_lm = 0; a_w = 0; a_h = 0;
        end else if (p_upd) begin
            a_al = s_al; a_set = s_set; a_dt = s_dt; a_lm = s_lm; a_w = s_w; a_h = s_h;
        end
        p_rst = 0; p_upd = 0;
        if (we) begin
            case (a)
                'h00: begin
                    s_en = d[0]; s_ext = d[8]; s_al = d[20]; s_swap = d[31];
                    p_rst = d[4]; p_upd = d[16];
                end
                'h04: begin s_ln = d & 'h1F; s_set = (d >> 27) & 'h1F; end
                'h08: begin s_lm = d & 3; s_dt = (d >> 2) & 'h3F; end
                'h2C: begin s_w = (d >> 16) & 'hFFFF; s_h = d & 'hFFFF; end
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk(tag, "rx_enable", rx_enable, s_en);
        chk(tag, "pair_swap", pair_swap, s_swap);
        chk(tag, "ext_clk_sel", ext_clk_sel, s_ext);
        chk(tag, "lane_en", lane_en, s_en ? s_ln : 0);
        chk(tag, "soft_rst_pulse", soft_rst_pulse, p_rst);
        chk(tag, "act_align32", act_align32, a_al);
        chk(tag, "act_settle", act_settle, a_set);
        chk(tag, "act_dtype", act_dtype, a_dt);
        chk(tag, "act_lanes", act_lanes, a_lm + 1);
        chk(tag, "act_width", act_width, a_w);
        chk(tag, "act_height", act_height, a_h);
    endtask

    // one clock: drive after negedge, check read data before edge, outputs after
    task automatic step(input string tag, input bit we, input int a, input int d);
        bus_wr = we; bus_addr = a[7:0]; bus_wdata = d;
        #1;
        chk(tag, "bus_rdata", bus_rdata, m_read(a) & 32'hFFFF_FFFF);
        @(posedge clk);
        m_edge(we, a, d);
        #1;
        chk_outs(tag);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input int a);
        step(tag, 1'b0, a, 0);
    endtask

    task automatic wr(input string tag, input int a, input int d);
        step(tag, 1'b1, a, d);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        s_en = 0; s_swap = 0; s_ext = 0; s_al = 0; a_al = 0; p_rst = 0; p_upd = 0;
        s_set = 0; s_ln = 0; s_dt = 0; s_lm = 0; s_w = 0; s_h = 0;
        a_set = 0; a_dt = 0; a_lm = 0; a_w = 0; a_h = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1", 'h00); rd("R1", 'h04); rd("R1", 'h08); rd("R1", 'h2C);
        chk("R1", "act_lanes_reset", act_lanes, 1);

        // R2 control readback, command bits read zero
        wr("R2", 'h00, 32'h8010_0101);
        rd("R2", 'h00);
        wr("R2", 'h00, 32'h7FEF_FEEE);
        rd("R2", 'h00);
        chk("R2", "ctrl_word", bus_rdata, 0);

        // R3 PHY word
        wr("R3", 'h04, 32'hFFFF_FFFF);
        rd("R3", 'h04);
        wr("R3", 'h04, 32'h5000_0015);
        rd("R3", 'h04);

        // R4 configuration word, type codes
        wr("R4", 'h08, 32'hFFFF_FFFF);
        rd("R4", 'h08);
        wr("R4", 'h08, (32'h1E << 2) | 3);
        rd("R4", 'h08);

        // R5 resolution extremes
        wr("R5", 'h2C, 32'hFFFF_FFFF);
        rd("R5", 'h2C);
        wr("R5", 'h2C, 32'h0780_0438);
        rd("R5", 'h2C);

        // R6 nothing active yet despite staged values
        rd("R6", 'h00);
        chk("R6", "act_width_still_zero", act_width, 0);

        // R7 shadow update with enable and alignment
        wr("R7", 'h00, 32'h0011_0001);
        rd("R7", 'h00);
        chk("R7", "act_width_loaded", act_width, 16'h0780);
        chk("R8", "act_lanes_four", act_lanes, 4);

        // R7 config write directly after update request
        wr("R7", 'h08, (32'h2B << 2) | 1);
        wr("R7", 'h00, 32'h0001_0001);
        wr("R7", 'h08, (32'h2A << 2) | 0);
        rd("R7", 'h08);
        chk("R7", "dtype_old_kept", act_dtype, 6'h2B);
        wr("R8", 'h00, 32'h0001_0001);
        rd("R8", 'h00);
        chk("R8", "act_lanes_one", act_lanes, 1);
        wr("R8", 'h08, (32'h30 << 2) | 2);
        wr("R8", 'h00, 32'h0001_0001);
        rd("R8", 'h00);
        chk("R8", "act_lanes_three", act_lanes, 3);

        // R6 staged edits do not leak
        wr("R6", 'h2C, 32'h0001_0002);
        wr("R6", 'h04, 32'h0800_0003);
        rd("R6", 'h00);
        chk("R6", "act_height_held", act_height, 16'h0438);

        // R9 soft reset
        wr("R9", 'h00, 32'h0000_0011);
        chk("R9", "pulse_high", soft_rst_pulse, 1);
        rd("R9", 'h00);
        chk("R9", "pulse_cleared", soft_rst_pulse, 0);
        chk("R9", "act_width_cleared", act_width, 0);
        rd("R9", 'h2C); rd("R9", 'h04); rd("R9", 'h08);
        wr("R9", 'h00, 32'h0000_0011);
        wr("R9", 'h00, 32'h0000_0011);
        rd("R9", 'h00);

        // R10 reset and update together
        wr("R10", 'h00, 32'h0001_0001);
        rd("R10", 'h00);
        wr("R10", 'h00, 32'h0011_0011);
        rd("R10", 'h00);
        chk("R10", "act_dtype_cleared", act_dtype, 0);
        chk("R10", "act_settle_cleared", act_settle, 0);

        // R11 unmapped offsets
        wr("R11", 'h10, 32'hFFFF_FFFF);
        wr("R11", 'h0C, 32'hFFFF_FFFF);
        wr("R11", 'h01, 32'hFFFF_FFFF);
        wr("R11", 'hFC, 32'h0001_0010);
        rd("R11", 'h10); rd("R11", 'h30); rd("R11", 'h02);
        rd("R11", 'h00); rd("R11", 'h04); rd("R11", 'h08); rd("R11", 'h2C);

        // R12 lane gating
        wr("R12", 'h04, 32'h0000_001F);
        wr("R12", 'h00, 32'h0000_0000);
        chk("R12", "lane_en_gated", lane_en, 0);
        wr("R12", 'h00, 32'h8000_0101);
        chk("R12", "lane_en_open", lane_en, 5'h1F);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule